// File: doc/BRIEF.md
# Battery Charge Cycle Controller

This block sequences one battery charge cycle from start to finish. It takes already-digitized comparator results as inputs: battery below the low-voltage level, battery below the recharge level, and charge current below the termination level. It also takes a charge enable, a termination enable and a periodic timing tick. From these it selects the current reference that the analog loop regulates to: off, precharge (one tenth of full current), or fast charge. Each time fast charge is entered, a step index raises the reference in equal increments. The block also reports whether a cycle is running, whether the battery is finished, and whether precharge timed out.

A cycle starts only after the enable has been held for a power-up delay. A deeply discharged battery is revived at the precharge level, and precharge is bounded by a fault timeout. Once the battery rises above the low-voltage level, the current soft-starts and then regulates at full level. When the battery is full and the current has tapered, the cycle ends after a deglitch interval and a qualification interval. A later drop below the recharge level starts a new cycle automatically.

The analog comparators, the regulation loops and the power stage sit outside this block. Every duration is defined in microseconds and converted to tick counts by the `TICK_US` parameter (the tick period in microseconds). A bench can therefore shrink all timers together.

Top module: `charge_cycle_ctrl`

## Requirements
- R1: After reset, and one clock edge after `chgEn` is seen low in any state, `refSel` is 0, `ssStep` is 0 and `charging`, `chargeDone` and `timeoutFault` are all 0. This is the only way to clear a done or fault indication.
- R2: After `chgEn` is first seen high, the first edge moves to a waiting state. Charging then begins on the tick edge that completes ENN ticks after that, where ENN is the tick count for 1.5 s.
- R3: If the filtered low-voltage flag is set when charging begins, or is set again while fast charging, `refSel` becomes 1 (precharge, one tenth current) and `charging` is 1.
- R4: If precharge lasts PREN ticks (30 minutes) without the filtered low-voltage flag clearing, `timeoutFault` goes to 1 with `refSel` 0 and `charging` 0. It stays 1 while `chgEn` stays high, whatever the comparator inputs do.
- R5: The low-voltage flag `batLow` is filtered for 25 ms worth of ticks on both edges. The state machine acts one edge after the filtered value changes.
- R6: Every entry into fast charge sets `refSel` to 2 with `ssStep` 0. `ssStep` then rises by one every SSN ticks (1.6 ms) up to SS_STEPS-1 and holds there for the rest of fast charge.
- R7: While fast charging with `termEn` high, the termination condition (`batBelowRech` low and `curBelowTerm` high) must hold through a 100 ms filter and then a 250 ms qualification window. `chargeDone` then goes to 1 with `refSel` 0. A pulse shorter than the filter has no effect.
- R8: With `termEn` low, termination never happens and fast charge continues with `chargeDone` 0.
- R9: When done, `batBelowRech` filtered for 10 ms starts a new cycle at precharge or soft-start, depending on the low-voltage flag.
- R10: Timers and filters advance only on clock edges where `tick` is 1. A duration of T µs lasts max(1, (T + TICK_US/2) / TICK_US) ticks, using integer division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing strobe, one clock wide, period TICK_US µs |
| chgEn | input | 1 | Charge enable |
| termEn | input | 1 | Allows termination when high |
| batLow | input | 1 | Battery below low-voltage level (raw) |
| batBelowRech | input | 1 | Battery below recharge level (raw) |
| curBelowTerm | input | 1 | Charge current below termination level (raw) |
| refSel | output | 2 | Current reference: 0 off, 1 precharge, 2 fast |
| ssStep | output | $clog2(SS_STEPS) | Soft-start step index while fast |
| charging | output | 1 | A charge phase is active |
| chargeDone | output | 1 | Cycle terminated, battery full |
| timeoutFault | output | 1 | Precharge timeout latched |

## Verification
Each result has a fixed latency in clock edges, counted from the edge that first samples a changed input. The filter flips on the N-th ticked edge, and the state machine reacts one edge later. A state timer expires on the N-th ticked edge after the edge that entered the state. The state register drives the outputs directly. The bench drives inputs two nanoseconds after a rising edge and samples there. Every check therefore looks one edge before and exactly on the edge where a change is due, with N taken from the rounding rule in R10. With `tick` held high throughout, the filter and timer counts become edge counts, and a separate stretch with `tick` low shows that nothing advances without it.

// File: rtl/chg_pkg.sv
`timescale 1ns/1ps
package chg_pkg;

  typedef enum logic [1:0] {
    REF_OFF  = 2'd0,
    REF_PRE  = 2'd1,
    REF_FAST = 2'd2
  } refSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_PRE, ST_SOFT, ST_FAST, ST_QUAL, ST_DONE, ST_FAULT
  } state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic timerClr;
    logic stepClr;
    logic stepInc;
  } strobe_t;

  // microseconds to ticks, rounded, at least one
  function automatic int ticksFor(input int us, input int tickUs);
    int n;
    n = (us + tickUs / 2) / tickUs;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/chg_deglitch.sv
`timescale 1ns/1ps
module chg_deglitch #(
  parameter int DG   = 25,
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  localparam int CW = (DG > 1) ? $clog2(DG) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      filt <= INIT;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == CW'(DG - 1)) begin
        filt <= raw;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chg_datapath.sv
`timescale 1ns/1ps
module chg_datapath
  import chg_pkg::*;
#(
  parameter int TICK_US  = 1000,
  parameter int SS_STEPS = 8,
  localparam int SW      = $clog2(SS_STEPS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          batLow,
  input  logic          batBelowRech,
  input  logic          curBelowTerm,
  input  strobe_t       stb,
  output logic          lowF,
  output logic          rechF,
  output logic          termF,
  output logic          enHit,
  output logic          preHit,
  output logic          ssHit,
  output logic          qualHit,
  output logic          lastStep,
  output logic [SW-1:0] step
);
  localparam int ENN   = ticksFor(1_500_000, TICK_US);
  localparam int PREN  = ticksFor(1_800_000_000, TICK_US);
  localparam int SSN   = ticksFor(1_600, TICK_US);
  localparam int QN    = ticksFor(250_000, TICK_US);
  localparam int LOWDG = ticksFor(25_000, TICK_US);
  localparam int TDG   = ticksFor(100_000, TICK_US);
  localparam int RDG   = ticksFor(10_000, TICK_US);
  localparam int TMAX  = (PREN > ENN) ? PREN : ENN;
  localparam int TW    = $clog2(TMAX + 1);

  logic [TW-1:0] timer;

  chg_deglitch #(.DG(LOWDG), .INIT(1'b1)) lowDg_i (
    .clk(clk), .rstN(rstN), .tick(tick), .raw(batLow), .filt(lowF));
  chg_deglitch #(.DG(RDG), .INIT(1'b0)) rechDg_i (
    .clk(clk), .rstN(rstN), .tick(tick), .raw(batBelowRech), .filt(rechF));
  chg_deglitch #(.DG(TDG), .INIT(1'b0)) termDg_i (
    .clk(clk), .rstN(rstN), .tick(tick), .raw(!batBelowRech && curBelowTerm),
    .filt(termF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          timer <= '0;
    else if (stb.timerClr)              timer <= '0;
    else if (tick && timer != TW'(TMAX)) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            step <= '0;
    else if (stb.stepClr) step <= '0;
    else if (stb.stepInc) step <= step + 1'b1;
  end

  assign enHit    = tick && (timer == TW'(ENN - 1));
  assign preHit   = tick && (timer == TW'(PREN - 1));
  assign ssHit    = tick && (timer == TW'(SSN - 1));
  assign qualHit  = tick && (timer == TW'(QN - 1));
  assign lastStep = (step == SW'(SS_STEPS - 1));
endmodule

// File: rtl/chg_ctrl.sv
`timescale 1ns/1ps
module chg_ctrl
  import chg_pkg::*;
#(
  parameter int SS_STEPS = 8,
  localparam int SW      = $clog2(SS_STEPS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chgEn,
  input  logic          termEn,
  input  logic          lowF,
  input  logic          rechF,
  input  logic          termF,
  input  logic          enHit,
  input  logic          preHit,
  input  logic          ssHit,
  input  logic          qualHit,
  input  logic          lastStep,
  input  logic [SW-1:0] step,
  output strobe_t       stb,
  output logic [1:0]    refSel,
  output logic [SW-1:0] ssStep,
  output logic          charging,
  output logic          chargeDone,
  output logic          timeoutFault
);
  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt         = state;
    stb         = '0;
    if (!chgEn) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: nxt = ST_WAIT;
        ST_WAIT: if (enHit) nxt = lowF ? ST_PRE : ST_SOFT;
        ST_PRE: begin
          if (!lowF)       nxt = ST_SOFT;
          else if (preHit) nxt = ST_FAULT;
        end
        ST_SOFT: begin
          if (lowF) nxt = ST_PRE;
          else if (ssHit) begin
            if (lastStep) nxt = ST_FAST;
            else          stb.stepInc = 1'b1;
            stb.timerClr = 1'b1;
          end
        end
        ST_FAST: begin
          if (lowF)                nxt = ST_PRE;
          else if (termEn && termF) nxt = ST_QUAL;
        end
        ST_QUAL: begin
          if (lowF)                  nxt = ST_PRE;
          else if (!termEn || !termF) nxt = ST_FAST;
          else if (qualHit)          nxt = ST_DONE;
        end
        ST_DONE:  if (rechF) nxt = lowF ? ST_PRE : ST_SOFT;
        ST_FAULT: nxt = ST_FAULT;
        default:  nxt = ST_IDLE;
      endcase
    end
    if (nxt != state) stb.timerClr = 1'b1;
    stb.stepClr = (nxt == ST_SOFT) && (state != ST_SOFT);
  end

  always_comb begin
    refSel = REF_OFF;
    ssStep = '0;
    unique case (state)
      ST_PRE:           refSel = REF_PRE;
      ST_SOFT: begin
        refSel = REF_FAST;
        ssStep = step;
      end
      ST_FAST, ST_QUAL: begin
        refSel = REF_FAST;
        ssStep = SW'(SS_STEPS - 1);
      end
      default: refSel = REF_OFF;
    endcase
  end

  assign charging     = (refSel != REF_OFF);
  assign chargeDone   = (state == ST_DONE);
  assign timeoutFault = (state == ST_FAULT);
endmodule

// File: rtl/charge_cycle_ctrl.sv
`timescale 1ns/1ps
module charge_cycle_ctrl
  import chg_pkg::*;
#(
  parameter int TICK_US  = 1000,
  parameter int SS_STEPS = 8,
  localparam int SW      = $clog2(SS_STEPS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          chgEn,
  input  logic          termEn,
  input  logic          batLow,
  input  logic          batBelowRech,
  input  logic          curBelowTerm,
  output logic [1:0]    refSel,
  output logic [SW-1:0] ssStep,
  output logic          charging,
  output logic          chargeDone,
  output logic          timeoutFault
);
  strobe_t       stb;
  logic          lowF, rechF, termF;
  logic          enHit, preHit, ssHit, qualHit, lastStep;
  logic [SW-1:0] step;

  chg_datapath #(.TICK_US(TICK_US), .SS_STEPS(SS_STEPS)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .batLow(batLow),
    .batBelowRech(batBelowRech), .curBelowTerm(curBelowTerm), .stb(stb),
    .lowF(lowF), .rechF(rechF), .termF(termF), .enHit(enHit),
    .preHit(preHit), .ssHit(ssHit), .qualHit(qualHit),
    .lastStep(lastStep), .step(step));

  chg_ctrl #(.SS_STEPS(SS_STEPS)) ctrl_i (
    .clk(clk), .rstN(rstN), .chgEn(chgEn), .termEn(termEn), .lowF(lowF),
    .rechF(rechF), .termF(termF), .enHit(enHit), .preHit(preHit),
    .ssHit(ssHit), .qualHit(qualHit), .lastStep(lastStep), .step(step),
    .stb(stb), .refSel(refSel), .ssStep(ssStep), .charging(charging),
    .chargeDone(chargeDone), .timeoutFault(timeoutFault));
endmodule

// File: rtl/chg_cycle_chk.sv
`timescale 1ns/1ps
module chg_cycle_chk #(
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          chgEn,
  input logic          termEn,
  input logic [1:0]    refSel,
  input logic [SW-1:0] ssStep,
  input logic          charging,
  input logic          chargeDone,
  input logic          timeoutFault
);
  // R1
  disable_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chgEn |=> (!charging && !chargeDone && !timeoutFault));

  // R2
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(charging) |-> $past(chgEn));

  // R4
  fault_from_precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFault) |-> ($past(refSel) == 2'd1));

  // R4
  fault_clears_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutFault) |-> !$past(chgEn));

  // R6
  soft_start_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refSel == 2'd2 && $past(refSel) != 2'd2) |-> (ssStep == '0));

  // R6
  soft_start_rising_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refSel == 2'd2 && $past(refSel) == 2'd2) |-> (ssStep >= $past(ssStep)));

  // R8
  done_needs_term_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chargeDone) |-> $past(termEn));
endmodule

bind charge_cycle_ctrl chg_cycle_chk #(.SW(SW)) chk_i (
  .clk(clk), .rstN(rstN), .chgEn(chgEn), .termEn(termEn), .refSel(refSel),
  .ssStep(ssStep), .charging(charging), .chargeDone(chargeDone),
  .timeoutFault(timeoutFault));

// File: tb/charge_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module charge_cycle_ctrl_tb_top;
  localparam int TICK_US  = 50_000;
  localparam int SS_STEPS = 8;
  localparam int SW       = $clog2(SS_STEPS);

  function automatic int tk(input int us);
    int n;
    n = (us + TICK_US / 2) / TICK_US;
    return (n < 1) ? 1 : n;
  endfunction

  localparam int ENN   = tk(1_500_000);
  localparam int PREN  = tk(1_800_000_000);
  localparam int SSN   = tk(1_600);
  localparam int QN    = tk(250_000);
  localparam int LOWDG = tk(25_000);
  localparam int TDG   = tk(100_000);
  localparam int RDG   = tk(10_000);

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic chgEn = 1'b0, termEn = 1'b0, batLow = 1'b1;
  logic batBelowRech = 1'b0, curBelowTerm = 1'b0;
  logic [1:0]    refSel;
  logic [SW-1:0] ssStep;
  logic charging, chargeDone, timeoutFault;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  charge_cycle_ctrl #(.TICK_US(TICK_US), .SS_STEPS(SS_STEPS)) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .chgEn(chgEn), .termEn(termEn),
    .batLow(batLow), .batBelowRech(batBelowRech), .curBelowTerm(curBelowTerm),
    .refSel(refSel), .ssStep(ssStep), .charging(charging),
    .chargeDone(chargeDone), .timeoutFault(timeoutFault));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    adv(3);
    rstN = 1'b1;
    adv(1);
    chk("R1 reset refSel", refSel, 0);
    chk("R1 reset ssStep", ssStep, 0);
    chk("R1 reset flags", {charging, chargeDone, timeoutFault}, 0);

    // R10: no tick, no progress
    chgEn = 1'b1;
    adv(101);
    chk("R10 frozen without tick", charging, 0);
    tick = 1'b1;
    adv(ENN - 1);
    chk("R2 before enable delay", refSel, 0);
    adv(1);
    chk("R3 precharge entered", refSel, 1);
    chk("R3 charging", charging, 1);

    // R4 timeout
    adv(PREN - 1);
    chk("R4 no fault before timeout", timeoutFault, 0);
    adv(1);
    chk("R4 fault at timeout", timeoutFault, 1);
    chk("R4 reference off", refSel, 0);
    chk("R4 not charging", charging, 0);
    batLow = 1'b0;
    adv(10);
    chk("R4 fault latched", timeoutFault, 1);
    chgEn = 1'b0;
    adv(1);
    chk("R1 fault cleared", timeoutFault, 0);
    batLow = 1'b1;
    adv(3);
    chgEn = 1'b1;
    adv(ENN + 1);
    chk("R3 precharge again", refSel, 1);

    // R5 / R6
    batLow = 1'b0;
    adv(LOWDG);
    chk("R5 still precharge", refSel, 1);
    adv(1);
    chk("R6 fast entry", refSel, 2);
    chk("R6 step zero", ssStep, 0);
    for (int k = 1; k < SS_STEPS; k++) begin
      adv(SSN);
      chk("R6 step index", ssStep, k);
    end
    adv(5);
    chk("R6 holds last step", ssStep, SS_STEPS - 1);
    batLow = 1'b1;
    adv(LOWDG);
    chk("R5 fast until filtered", refSel, 2);
    adv(1);
    chk("R5 back to precharge", refSel, 1);
    batLow = 1'b0;
    adv(LOWDG + 1);
    chk("R6 re-entry step zero", ssStep, 0);
    chk("R6 re-entry fast", refSel, 2);
    adv(SS_STEPS * SSN + 2);

    // R8
    termEn = 1'b0; curBelowTerm = 1'b1; batBelowRech = 1'b0;
    adv(50);
    chk("R8 no termination", chargeDone, 0);
    chk("R8 still fast", refSel, 2);

    // R7
    termEn = 1'b1;
    adv(QN);
    chk("R7 qualifying", chargeDone, 0);
    adv(1);
    chk("R7 done", chargeDone, 1);
    chk("R7 reference off", refSel, 0);

    // R9
    batBelowRech = 1'b1;
    adv(RDG);
    chk("R9 still done", chargeDone, 1);
    adv(1);
    chk("R9 new cycle", refSel, 2);
    chk("R9 soft-start", ssStep, 0);

    curBelowTerm = 1'b0;
    adv(20);
    batBelowRech = 1'b0;
    adv(5);
    curBelowTerm = 1'b1;
    adv(TDG - 1);
    curBelowTerm = 1'b0;
    adv(30);
    chk("R7 short pulse ignored", chargeDone, 0);
    chk("R7 short pulse fast", refSel, 2);
    curBelowTerm = 1'b1;
    adv(TDG + QN);
    chk("R7 filter plus window", chargeDone, 0);
    adv(1);
    chk("R7 done after filter", chargeDone, 1);

    chgEn = 1'b0;
    adv(1);
    chk("R1 done cleared", chargeDone, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule